// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Service Sequence

This block is a watchdog timer for a small 8-bit microcontroller. Software reaches it through three byte-wide registers on a simple register bus. Two of these registers can also be written one bit at a time. Writing a one to the run flag starts a 16-bit counter. The counter loads a programmable start value and then advances by one on each prescale-enable pulse. If software lets the counter pass its all-ones value, the block drives a reset request for a fixed number of clock cycles. It also sets a sticky status flag, which keeps its value through that reset.

Servicing the timer is deliberately a two-step ritual. Software first sets the arm flag. The very next register write must then set the run flag. Only that ordered pair reloads the counter. A lone run-flag write does not service the timer. Any other write placed between the two steps throws the arming away. The arm flag clears itself after every write that follows it. Once running, the timer cannot be stopped by software. Only the power-on reset or the watchdog's own reset returns it to idle.

Top module: `wdog_pair_refresh`

## Requirements
- R1: After power-on reset, the arm register (0xA8), run register (0xB8) and status register (0xA9) all read 0x00, and `wd_rst_req` is low. With the timer idle, prescale pulses cause no reset request.
- R2: Writing a one to the run flag starts an idle timer, loading the counter with `reload_value`. The run flag is bit 6 of 0xB8, written either by a byte write or by a bit write to bit address 0xBE. Bit 6 of 0xB8 then reads 1.
- R3: The counter changes only on cycles where `tick` is high. Counting from a load of `reload_value`, the overflow happens on tick number 2^16 - `reload_value`.
- R4: Software can service a running timer with two writes. The first sets the arm flag (bit 6 of 0xA8, bit address 0xAE). The very next register write sets the run flag. This pair reloads the counter with `reload_value`.
- R5: A write that sets the run flag without the arm flag set does not reload a running counter.
- R6: Arming is cancelled by any register write after the arming write that does not set the run flag. Bit 6 of 0xA8 then reads 0, and no reload occurs.
- R7: The arm flag reads 0 after a completed service sequence.
- R8: A running timer cannot be stopped. Writing a zero to the run flag leaves bit 6 of 0xB8 reading 1, and the overflow still happens on schedule.
- R9: On overflow, `wd_rst_req` is high for exactly RST_CYCLES (default 4) consecutive cycles. In the same step, bit 6 of 0xA9 is set, the timer returns to idle, and 0xA8 and 0xB8 are cleared to 0x00.
- R10: The status flag keeps its value through the watchdog reset. Software can clear and set it with byte writes to 0xA9. Only the power-on reset clears it otherwise.
- R11: Bits other than the flag bits in 0xA8 and 0xB8 store and read back as written. A bit write at bit address B writes bit B[2:0] of byte address {B[7:3],000}.
- R12: Register writes issued while `wd_rst_req` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tick | input | 1 | Prescale enable; one count per high cycle |
| reload_value | input | 16 | Counter start value on start and service |
| byte_we | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address for a bit write |
| bit_val | input | 1 | Value written by a bit write |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| wd_rst_req | output | 1 | Reset request from the watchdog |

## Verification
A counter that holds a wrong value shows up only as a reset request arriving early or late. The bench therefore counts ticks exactly and checks `wd_rst_req` on the tick just before the expected overflow and on the overflow tick itself. An arm flag that is not cleared, or a run flag that does not stick, shows at the read port as soon as the next write finishes. A faulty service decision stays hidden until the next overflow, which comes at most 16 ticks later in these tests. A bad reset-pulse counter shows within RST_CYCLES + 1 cycles as a wrong pulse length.

// File: rtl/wdog_pair_pkg.sv
package wdog_pair_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned FLAG_BIT = 6;

  localparam logic [ADDR_W-1:0] ADDR_ARM  = 8'hA8;
  localparam logic [ADDR_W-1:0] ADDR_RUN  = 8'hB8;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'hA9;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ARM  = 2'd1,
    TGT_RUN  = 2'd2,
    TGT_STAT = 2'd3
  } wr_tgt_e;

  typedef struct packed {
    logic              valid;
    wr_tgt_e           tgt;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

  function automatic wr_tgt_e addr_to_tgt(input logic [ADDR_W-1:0] a);
    wr_tgt_e t;
    case (a)
      ADDR_ARM:  t = TGT_ARM;
      ADDR_RUN:  t = TGT_RUN;
      ADDR_STAT: t = TGT_STAT;
      default:   t = TGT_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/wdog_wr_decode.sv
module wdog_wr_decode
  import wdog_pair_pkg::*;
(
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_val,
  output wr_cmd_t           cmd
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] bit_base;
  wr_tgt_e           byte_tgt;
  wr_tgt_e           bit_tgt;
  logic [DATA_W-1:0] bit_mask;

  always_comb begin
    bit_base = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    byte_tgt = addr_to_tgt(byte_addr);
    bit_tgt  = addr_to_tgt(bit_base);
    bit_mask = '0;
    bit_mask[bit_addr[IDX_W-1:0]] = 1'b1;
  end

  // Byte writes win over a simultaneous bit write; only the two
  // byte addresses on an 8-byte boundary accept bit writes.
  always_comb begin
    cmd = '0;
    if (byte_we) begin
      cmd.tgt   = byte_tgt;
      cmd.valid = (byte_tgt != TGT_NONE);
      cmd.mask  = '1;
      cmd.data  = byte_data;
    end else if (bit_we) begin
      cmd.tgt   = bit_tgt;
      cmd.valid = (bit_tgt == TGT_ARM) || (bit_tgt == TGT_RUN);
      cmd.mask  = bit_mask;
      cmd.data  = {DATA_W{bit_val}} & bit_mask;
    end
  end
endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_cmd_t           cmd,
  input  logic              blocked,
  input  logic              running,
  input  logic              ovf,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_req,
  output logic              refresh_req,
  output logic              wr_acc,
  output logic              arm_set,
  output logic              arm_q,
  output logic              stat_flag
);
  logic [DATA_W-1:0] arm_reg_q,  arm_reg_d;
  logic [DATA_W-1:0] run_reg_q,  run_reg_d;
  logic [DATA_W-1:0] stat_reg_q, stat_reg_d;
  logic              run_set;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] msk,
                                              input logic [DATA_W-1:0] val);
    return (old_v & ~msk) | (val & msk);
  endfunction

  always_comb begin
    wr_acc      = cmd.valid && !blocked;
    arm_set     = wr_acc && (cmd.tgt == TGT_ARM) && cmd.mask[FLAG_BIT] && cmd.data[FLAG_BIT];
    run_set     = wr_acc && (cmd.tgt == TGT_RUN) && cmd.mask[FLAG_BIT] && cmd.data[FLAG_BIT];
    arm_q       = arm_reg_q[FLAG_BIT];
    stat_flag   = stat_reg_q[FLAG_BIT];
    start_req   = run_set && !running;
    refresh_req = run_set && running && arm_q;
  end

  always_comb begin
    arm_reg_d  = arm_reg_q;
    run_reg_d  = run_reg_q;
    stat_reg_d = stat_reg_q;
    if (ovf) begin
      arm_reg_d = '0;
      run_reg_d = '0;
      stat_reg_d[FLAG_BIT] = 1'b1;
    end else if (wr_acc) begin
      case (cmd.tgt)
        TGT_ARM:  arm_reg_d  = merge(arm_reg_q,  cmd.mask, cmd.data);
        TGT_RUN:  run_reg_d  = merge(run_reg_q,  cmd.mask, cmd.data);
        TGT_STAT: stat_reg_d = merge(stat_reg_q, cmd.mask, cmd.data);
        default:  ;
      endcase
      // Arm holds only until the next accepted write of any kind.
      arm_reg_d[FLAG_BIT] = arm_set;
      // Run state lives in the counter; the stored bit stays zero.
      run_reg_d[FLAG_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_reg_q  <= '0;
      run_reg_q  <= '0;
      stat_reg_q <= '0;
    end else begin
      arm_reg_q  <= arm_reg_d;
      run_reg_q  <= run_reg_d;
      stat_reg_q <= stat_reg_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_ARM:  rd_data = arm_reg_q;
      ADDR_RUN:  rd_data = run_reg_q | (DATA_W'(running) << FLAG_BIT);
      ADDR_STAT: rd_data = stat_reg_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_req,
  input  logic             refresh_req,
  input  logic [CNT_W-1:0] reload_value,
  output logic             running,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d;
  logic             load;
  logic             adv;

  always_comb begin
    load  = start_req || refresh_req;
    adv   = running && tick;
    // A service landing on the final tick still saves the timer.
    ovf   = adv && (cnt_q == CNT_MAX) && !load;
    run_d = running;
    cnt_d = cnt_q;
    if (ovf) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (load) begin
      run_d = 1'b1;
      cnt_d = reload_value;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else begin
      running <= run_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (fire)
      left_d = CW'(PULSE_CYCLES);
    else if (left_q != '0)
      left_d = left_q - 1'b1;
    active = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end
endmodule

// File: rtl/wdog_pair_refresh.sv
module wdog_pair_refresh
  import wdog_pair_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  reload_value,
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wd_rst_req
);
  logic [1:0] por_sync_q;
  logic       rst_n_sync;
  wr_cmd_t    cmd;
  logic       start_req, refresh_req, wr_acc, arm_set, arm_q, stat_flag;
  logic       running, ovf;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_sync_q <= '0;
    else        por_sync_q <= {por_sync_q[0], 1'b1};
  end
  assign rst_n_sync = por_sync_q[1];

  wdog_wr_decode u_dec (
    .byte_we   (byte_we),
    .byte_addr (wr_addr),
    .byte_data (wr_data),
    .bit_we    (bit_we),
    .bit_addr  (bit_addr),
    .bit_val   (bit_val),
    .cmd       (cmd)
  );

  wdog_ctrl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cmd         (cmd),
    .blocked     (wd_rst_req),
    .running     (running),
    .ovf         (ovf),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .start_req   (start_req),
    .refresh_req (refresh_req),
    .wr_acc      (wr_acc),
    .arm_set     (arm_set),
    .arm_q       (arm_q),
    .stat_flag   (stat_flag)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .tick         (tick),
    .start_req    (start_req),
    .refresh_req  (refresh_req),
    .reload_value (reload_value),
    .running      (running),
    .ovf          (ovf)
  );

  wdog_rst_pulse #(.PULSE_CYCLES(RST_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .fire   (ovf),
    .active (wd_rst_req)
  );
endmodule

// File: rtl/wdog_pair_checker.sv
module wdog_pair_checker #(
  parameter int unsigned RST_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic wd_rst_req,
  input logic running,
  input logic ovf,
  input logic arm_q,
  input logic arm_set,
  input logic wr_acc,
  input logic stat_flag
);
  localparam int unsigned HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_q <= '0;
    else if (wd_rst_req) hi_q <= hi_q + 1'b1;
    else                 hi_q <= '0;
  end

  p_arm_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && wr_acc && !arm_set) |=> !arm_q);

  p_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ovf) |=> running);

  p_ovf_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (wd_rst_req && stat_flag && !running));

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> (hi_q < HW'(RST_CYCLES)));

  p_status_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_req) |-> stat_flag);

  p_idle_in_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> (!running && !arm_q));
endmodule

bind wdog_pair_refresh wdog_pair_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .wd_rst_req (wd_rst_req),
  .running    (running),
  .ovf        (ovf),
  .arm_q      (arm_q),
  .arm_set    (arm_set),
  .wr_acc     (wr_acc),
  .stat_flag  (stat_flag)
);

// File: tb/wdog_pair_refresh_bench.sv
module wdog_pair_refresh_bench;
  localparam int unsigned RST_CYCLES = 4;
  localparam logic [15:0] RELOAD = 16'hFFF0;   // 16 ticks to overflow

  logic       clk = 1'b0;
  logic       por_n;
  logic       tick;
  logic [15:0] reload_value;
  logic       byte_we, bit_we, bit_val;
  logic [7:0] wr_addr, wr_data, bit_addr, rd_addr;
  logic [7:0] rd_data;
  logic       wd_rst_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdog_pair_refresh #(.CNT_W(16), .RST_CYCLES(RST_CYCLES)) u_wdog_pair_refresh (
    .clk(clk), .por_n(por_n), .tick(tick), .reload_value(reload_value),
    .byte_we(byte_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
    .rd_addr(rd_addr), .rd_data(rd_data), .wd_rst_req(wd_rst_req)
  );

  localparam logic [2:0] OP_BYTE = 3'd0;
  localparam logic [2:0] OP_BIT  = 3'd1;
  localparam logic [2:0] OP_READ = 3'd2;
  localparam logic [2:0] OP_TICK = 3'd3;
  localparam logic [2:0] OP_RSTQ = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{OP_READ, 8'hA8, 8'h00, 8'h00, 4'd1},  // R1
    '{OP_READ, 8'hB8, 8'h00, 8'h00, 4'd1},  // R1
    '{OP_READ, 8'hA9, 8'h00, 8'h00, 4'd1},  // R1
    '{OP_BYTE, 8'hA8, 8'h41, 8'h00, 4'd11},
    '{OP_READ, 8'hA8, 8'h00, 8'h41, 4'd11}, // R11 arm + bit0 stored
    '{OP_BYTE, 8'hA8, 8'h01, 8'h00, 4'd6},
    '{OP_READ, 8'hA8, 8'h00, 8'h01, 4'd6},  // R6
    '{OP_BIT,  8'hAE, 8'h01, 8'h00, 4'd4},  // arm by bit address
    '{OP_READ, 8'hA8, 8'h00, 8'h41, 4'd4},  // R4 armed
    '{OP_BIT,  8'hB9, 8'h01, 8'h00, 4'd6},  // intervening write
    '{OP_READ, 8'hA8, 8'h00, 8'h01, 4'd6},  // R6 cancelled
    '{OP_READ, 8'hB8, 8'h00, 8'h02, 4'd11}, // R11 bit write B9 -> 0xB8 bit1
    '{OP_BIT,  8'hBE, 8'h01, 8'h00, 4'd2},  // start
    '{OP_READ, 8'hB8, 8'h00, 8'h42, 4'd2},  // R2
    '{OP_BYTE, 8'hB8, 8'h00, 8'h00, 4'd8},  // try to stop
    '{OP_READ, 8'hB8, 8'h00, 8'h40, 4'd8},  // R8
    '{OP_TICK, 8'h00, 8'd15, 8'h00, 4'd3},
    '{OP_RSTQ, 8'h00, 8'h00, 8'h00, 4'd3},  // R3 not yet
    '{OP_TICK, 8'h00, 8'd1,  8'h00, 4'd3},
    '{OP_RSTQ, 8'h00, 8'h00, 8'h01, 4'd3},  // R3 overflow on 16th tick
    '{OP_READ, 8'hA9, 8'h00, 8'h40, 4'd9},  // R9 status
    '{OP_READ, 8'hB8, 8'h00, 8'h00, 4'd9}   // R9 control cleared
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    byte_we = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    byte_we = 1'b0;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    bit_we = 1'b1; bit_addr = a; bit_val = v;
    @(negedge clk);
    bit_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, {8'h00, rd_data}, {8'h00, exp});
  endtask

  task automatic wait_pulse_end();
    for (int i = 0; i < 50 && wd_rst_req; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic por_cycle();
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int hi;
    tick = 0; byte_we = 0; bit_we = 0; bit_val = 0;
    wr_addr = 0; wr_data = 0; bit_addr = 0; rd_addr = 0;
    reload_value = RELOAD;
    por_n = 1'b0;
    @(negedge clk);
    por_cycle();
    chk("R1 rst_req after por", {15'd0, wd_rst_req}, 16'd0);
    ticks(20);
    chk("R1 idle ignores ticks", {15'd0, wd_rst_req}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
      case (VECS[v].op)
        OP_BYTE: wr_byte(VECS[v].a, VECS[v].d);
        OP_BIT:  wr_bit(VECS[v].a, VECS[v].d[0]);
        OP_TICK: ticks(int'(VECS[v].d));
        OP_READ: rd_chk(tg, VECS[v].a, VECS[v].exp);
        OP_RSTQ: chk(tg, {15'd0, wd_rst_req}, {8'h00, VECS[v].exp});
        default: ;
      endcase
    end

    // R9 pulse length and R12 writes ignored during the pulse
    hi = wd_rst_req ? 1 : 0;
    wr_byte(8'hA8, 8'hC0);
    if (wd_rst_req) hi++;
    for (int i = 0; i < 20 && wd_rst_req; i++) begin
      @(negedge clk);
      if (wd_rst_req) hi++;
    end
    chk("R9 pulse length", 16'(hi), 16'(RST_CYCLES));
    rd_chk("R12 write during pulse dropped", 8'hA8, 8'h00);
    rd_chk("R10 status survives wd reset", 8'hA9, 8'h40);

    // R10 software clear and set
    wr_byte(8'hA9, 8'h00);
    rd_chk("R10 sw clear", 8'hA9, 8'h00);
    wr_byte(8'hA9, 8'h40);
    rd_chk("R10 sw set", 8'hA9, 8'h40);
    wr_byte(8'hA9, 8'h00);

    // R4 / R7 proper service sequence
    wr_byte(8'hB8, 8'h40);
    ticks(10);
    wr_byte(8'hA8, 8'h40);
    wr_bit(8'hBE, 1'b1);
    rd_chk("R7 arm cleared after service", 8'hA8, 8'h00);
    ticks(15);
    chk("R4 reload delays overflow", {15'd0, wd_rst_req}, 16'd0);
    ticks(1);
    chk("R4 overflow 16 ticks after service", {15'd0, wd_rst_req}, 16'd1);
    wait_pulse_end();

    // R5 lone start while running does not reload
    wr_byte(8'hB8, 8'h40);
    ticks(10);
    wr_bit(8'hBE, 1'b1);
    ticks(5);
    chk("R5 no early reset", {15'd0, wd_rst_req}, 16'd0);
    ticks(1);
    chk("R5 lone start did not service", {15'd0, wd_rst_req}, 16'd1);
    wait_pulse_end();

    // R6 intervening write cancels service
    wr_byte(8'hB8, 8'h40);
    ticks(10);
    wr_bit(8'hAE, 1'b1);
    wr_byte(8'hA9, 8'h00);
    wr_bit(8'hBE, 1'b1);
    ticks(5);
    chk("R6 no early reset", {15'd0, wd_rst_req}, 16'd0);
    ticks(1);
    chk("R6 cancelled service had no effect", {15'd0, wd_rst_req}, 16'd1);
    wait_pulse_end();

    // R3 counter holds without ticks
    wr_byte(8'hB8, 8'h40);
    repeat (40) @(negedge clk);
    ticks(15);
    chk("R3 holds without tick", {15'd0, wd_rst_req}, 16'd0);
    ticks(1);
    chk("R3 overflow after 16 ticks", {15'd0, wd_rst_req}, 16'd1);
    wait_pulse_end();

    // R1 power-on reset clears everything including status
    wr_byte(8'hB8, 8'h40);
    ticks(3);
    por_cycle();
    rd_chk("R1 status cleared by por", 8'hA9, 8'h00);
    rd_chk("R1 run cleared by por", 8'hB8, 8'h00);
    ticks(20);
    chk("R1 idle after por", {15'd0, wd_rst_req}, 16'd0);

    finish_run();
  end
endmodule